// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Unit

This unit decides, once per clock, whether a single pending interrupt request is accepted by the processor. When it is accepted, the unit commits the resulting state changes and produces the address that instruction fetch must jump to. The state changes are the saved program counter, the saved status word, the new status word and the cause register.

There are two kinds of accepted request. A request above level 1 vectors straight to a per-level handler, and the interrupted context is kept in that level's save slots. A level-1 request is turned into an ordinary exception instead. Its class is kernel, user or double, chosen from the exception-mode and user-mode bits of the incoming status word. Every redirect address can be moved through a vector-base input.

Inputs are sampled on a rising edge. A taken request shows its results on the registered outputs after that same edge, together with a one-cycle strobe.

Top module: `irq_dispatch`

## Requirements
- R1: A request is taken only when all three of these hold: `pend_level` is above `cur_level`, `pend_level` is at most `NLEVEL`, and the mask slot for that level ANDed with `int_set` and `int_en` is non-zero. Mask slot k-1 of `level_mask` (bits `(k-1)*INTW` upward) belongs to level k.
- R2: A taken request at level k > 1 stores `pc_i` in `epc_o` slot k-1 and `ps_i` in `eps_o` slot k-2. It writes level k into `ps_o[3:0]`, sets the exception-mode bit and reports class 0 (high-level interrupt).
- R3: Every taken level-1 request loads `cause_o` with the code 4.
- R4: A taken level-1 request while `ps_i[4]` (exception mode) is set reports class 3 (double exception). It saves `pc_i` in `depc_o` when `HAS_DEPC` is 1, and otherwise in `epc_o` slot 0.
- R5: A taken level-1 request while `ps_i[4]` is clear saves `pc_i` in `epc_o` slot 0. It reports class 2 (user) when `ps_i[5]` is set, and class 1 (kernel) otherwise.
- R6: After any taken request, `ps_o[4]` is 1. A level-1 take leaves all other status bits as they were in `ps_i`.
- R7: With relocation enabled, `redirect_o` equals `vecbase_i` plus the vector's offset from the default base. The offsets are 0x100+k*0x40 for level k > 1, 0x300 for kernel, 0x340 for user and 0x3C0 for double.
- R8: `taken_o` is high for exactly the one cycle after the edge that accepted the request.
- R9: A request that is not taken leaves `ps_o`, `redirect_o`, `exc_class_o`, `cause_o` and all save registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A pending request is presented |
| pend_level | input | LVLW | Level of the pending request |
| cur_level | input | LVLW | Current interrupt level of the processor |
| ps_i | input | PSW | Current status word |
| int_set | input | INTW | Raised interrupt lines |
| int_en | input | INTW | Enabled interrupt lines |
| level_mask | input | NLEVEL*INTW | Per-level line masks, slot k-1 for level k |
| pc_i | input | PCW | Program counter to save |
| vecbase_i | input | PCW | Current vector base |
| taken_o | output | 1 | One-cycle taken strobe |
| exc_class_o | output | 2 | 0 high-level, 1 kernel, 2 user, 3 double |
| redirect_o | output | PCW | New fetch address |
| ps_o | output | PSW | Updated status word |
| cause_o | output | CAUSEW | Exception cause register |
| epc_o | output | NLEVEL*PCW | Saved PC per level, slot k-1 for level k |
| eps_o | output | (NLEVEL-1)*PSW | Saved status per level, slot k-2 for level k |
| depc_o | output | PCW | Double-exception saved PC |

## Verification
The hardest case to reach is the double exception. It needs a level-1 request that passes the full mask and level test while the incoming status already has exception mode set. In that case the saved PC has to land in the double-exception register, and the level-1 slot written by the earlier level-1 take must stay as it was.

The stimulus therefore runs a kernel take, then a user take, then the double case. A second instance built without the double-exception register receives the same inputs, so the fallback into slot 0 is observed at the same moment.

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int NLEVEL = 6,
  parameter int LVLW = 4,
  parameter int INTW = 16,
  parameter int PCW = 32,
  parameter int PSW = 8,
  parameter int PS_LVL_LSB = 0,
  parameter int PS_EXCM_BIT = 4,
  parameter int PS_UM_BIT = 5,
  parameter bit HAS_DEPC = 1'b1,
  parameter bit RELOC_EN = 1'b1,
  parameter int CAUSEW = 6,
  parameter int L1_CAUSE = 4,
  parameter logic [PCW-1:0] DEF_VECBASE = 'h4000_0000,
  parameter int HI_OFS = 'h100,
  parameter int KERN_OFS = 'h300,
  parameter int USER_OFS = 'h340,
  parameter int DBL_OFS = 'h3C0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [LVLW-1:0]            pend_level,
  input  logic [LVLW-1:0]            cur_level,
  input  logic [PSW-1:0]             ps_i,
  input  logic [INTW-1:0]            int_set,
  input  logic [INTW-1:0]            int_en,
  input  logic [NLEVEL*INTW-1:0]     level_mask,
  input  logic [PCW-1:0]             pc_i,
  input  logic [PCW-1:0]             vecbase_i,
  output logic                       taken_o,
  output logic [1:0]                 exc_class_o,
  output logic [PCW-1:0]             redirect_o,
  output logic [PSW-1:0]             ps_o,
  output logic [CAUSEW-1:0]          cause_o,
  output logic [NLEVEL*PCW-1:0]      epc_o,
  output logic [(NLEVEL-1)*PSW-1:0]  eps_o,
  output logic [PCW-1:0]             depc_o
);
  localparam logic [1:0] CLS_HIGH = 2'd0, CLS_KERN = 2'd1, CLS_USER = 2'd2, CLS_DBL = 2'd3;

  logic [INTW-1:0] sel_mask;
  always_comb begin
    sel_mask = '0;
    for (int k = 1; k <= NLEVEL; k++)
      if (pend_level == LVLW'(k)) sel_mask = level_mask[(k-1)*INTW +: INTW];
  end

  wire excm  = ps_i[PS_EXCM_BIT];
  wire umode = ps_i[PS_UM_BIT];
  wire is_l1 = (pend_level == LVLW'(1));
  wire take  = req_valid && (pend_level > cur_level) &&
               (int'(pend_level) <= NLEVEL) && |(sel_mask & int_set & int_en);

  wire [1:0] cls = !is_l1 ? CLS_HIGH : excm ? CLS_DBL : umode ? CLS_USER : CLS_KERN;

  logic [PCW-1:0] ofs;
  always_comb begin
    case (cls)
      CLS_KERN: ofs = PCW'(KERN_OFS);
      CLS_USER: ofs = PCW'(USER_OFS);
      CLS_DBL:  ofs = PCW'(DBL_OFS);
      default:  ofs = PCW'(HI_OFS) + (PCW'(pend_level) << 6);
    endcase
  end

  wire [PCW-1:0] redir = RELOC_EN ? vecbase_i + ofs : DEF_VECBASE + ofs;

  logic [PSW-1:0] ps_next;
  always_comb begin
    ps_next = ps_i;
    if (!is_l1) ps_next[PS_LVL_LSB +: LVLW] = pend_level;
    ps_next[PS_EXCM_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken_o     <= 1'b0;
      exc_class_o <= CLS_HIGH;
      redirect_o  <= '0;
      ps_o        <= '0;
      cause_o     <= '0;
      epc_o       <= '0;
      eps_o       <= '0;
      depc_o      <= '0;
    end else begin
      taken_o <= take;
      if (take) begin
        ps_o        <= ps_next;
        exc_class_o <= cls;
        redirect_o  <= redir;
        if (is_l1) begin
          cause_o <= CAUSEW'(L1_CAUSE);
          if (excm && HAS_DEPC) depc_o <= pc_i;
          else epc_o[0 +: PCW] <= pc_i;
        end else begin
          for (int k = 2; k <= NLEVEL; k++)
            if (pend_level == LVLW'(k)) begin
              epc_o[(k-1)*PCW +: PCW] <= pc_i;
              eps_o[(k-2)*PSW +: PSW] <= ps_i;
            end
        end
      end
    end
  end
endmodule

module irq_dispatch_chk #(
  parameter int LVLW = 4,
  parameter int PSW = 8,
  parameter int PCW = 32,
  parameter int PS_LVL_LSB = 0,
  parameter int PS_EXCM_BIT = 4,
  parameter int CAUSEW = 6,
  parameter int L1_CAUSE = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [LVLW-1:0]   pend_level,
  input logic [LVLW-1:0]   cur_level,
  input logic              taken_o,
  input logic [1:0]        exc_class_o,
  input logic [PCW-1:0]    redirect_o,
  input logic [PSW-1:0]    ps_o,
  input logic [CAUSEW-1:0] cause_o
);
  p_low_level_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && pend_level <= cur_level |=> !taken_o);
  p_high_level_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o && exc_class_o == 2'd0 |-> ps_o[PS_LVL_LSB +: LVLW] == $past(pend_level));
  p_l1_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o && exc_class_o != 2'd0 |-> cause_o == CAUSEW'(L1_CAUSE));
  p_excm_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> ps_o[PS_EXCM_BIT]);
  p_take_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !taken_o);
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(ps_o) && $stable(redirect_o) && $stable(exc_class_o));
endmodule

bind irq_dispatch irq_dispatch_chk #(
  .LVLW(LVLW), .PSW(PSW), .PCW(PCW), .PS_LVL_LSB(PS_LVL_LSB),
  .PS_EXCM_BIT(PS_EXCM_BIT), .CAUSEW(CAUSEW), .L1_CAUSE(L1_CAUSE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pend_level(pend_level),
  .cur_level(cur_level), .taken_o(taken_o), .exc_class_o(exc_class_o),
  .redirect_o(redirect_o), .ps_o(ps_o), .cause_o(cause_o)
);

// File: tb/test_irq_dispatch.sv
module test_irq_dispatch;
  localparam int NL = 6, LW = 4, IW = 16, PW = 32, SW = 8, CW = 6;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [LW-1:0] pend_level = '0, cur_level = '0;
  logic [SW-1:0] ps_i = '0;
  logic [IW-1:0] int_set = '0, int_en = '0;
  logic [NL*IW-1:0] level_mask;
  logic [PW-1:0] pc_i = '0, vecbase_i = 32'h2000_0000;
  logic taken_o, taken_b;
  logic [1:0] exc_class_o, cls_b;
  logic [PW-1:0] redirect_o, redir_b, depc_o, depc_b;
  logic [SW-1:0] ps_o, ps_b;
  logic [CW-1:0] cause_o, cause_b;
  logic [NL*PW-1:0] epc_o, epc_b;
  logic [(NL-1)*SW-1:0] eps_o, eps_b;

  always #5 clk = ~clk;

  assign level_mask = {16'h0C00, 16'h0300, 16'h00C0, 16'h0030, 16'h000C, 16'h0003};

  irq_dispatch i_irq_dispatch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pend_level(pend_level),
    .cur_level(cur_level), .ps_i(ps_i), .int_set(int_set), .int_en(int_en),
    .level_mask(level_mask), .pc_i(pc_i), .vecbase_i(vecbase_i),
    .taken_o(taken_o), .exc_class_o(exc_class_o), .redirect_o(redirect_o),
    .ps_o(ps_o), .cause_o(cause_o), .epc_o(epc_o), .eps_o(eps_o), .depc_o(depc_o));

  irq_dispatch #(.HAS_DEPC(1'b0)) i_nodepc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pend_level(pend_level),
    .cur_level(cur_level), .ps_i(ps_i), .int_set(int_set), .int_en(int_en),
    .level_mask(level_mask), .pc_i(pc_i), .vecbase_i(vecbase_i),
    .taken_o(taken_b), .exc_class_o(cls_b), .redirect_o(redir_b),
    .ps_o(ps_b), .cause_o(cause_b), .epc_o(epc_b), .eps_o(eps_b), .depc_o(depc_b));

  typedef struct packed {
    logic [3:0]  pend;
    logic [3:0]  cur;
    logic [7:0]  ps;
    logic [15:0] set;
    logic [15:0] en;
    logic [31:0] pc;
    logic        take;
    logic [7:0]  ps_x;
    logic [1:0]  cls;
    logic [31:0] redir;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{4'd3, 4'd1, 8'h21, 16'h0010, 16'h0030, 32'h1000, 1'b1, 8'h33, 2'd0, 32'h2000_01C0},
    '{4'd2, 4'd2, 8'h00, 16'hFFFF, 16'hFFFF, 32'h1100, 1'b0, 8'h00, 2'd0, 32'h0},
    '{4'd7, 4'd0, 8'h00, 16'hFFFF, 16'hFFFF, 32'h1200, 1'b0, 8'h00, 2'd0, 32'h0},
    '{4'd3, 4'd0, 8'h00, 16'h0010, 16'h0020, 32'h1300, 1'b0, 8'h00, 2'd0, 32'h0},
    '{4'd1, 4'd0, 8'h00, 16'h0001, 16'h0001, 32'h2000, 1'b1, 8'h10, 2'd1, 32'h2000_0300},
    '{4'd1, 4'd0, 8'h20, 16'h0002, 16'h0003, 32'h3000, 1'b1, 8'h30, 2'd2, 32'h2000_0340},
    '{4'd1, 4'd0, 8'h10, 16'h0001, 16'h0001, 32'h4000, 1'b1, 8'h10, 2'd3, 32'h2000_03C0},
    '{4'd6, 4'd5, 8'h05, 16'h0800, 16'hFFFF, 32'h5000, 1'b1, 8'h16, 2'd0, 32'h2000_0280}
  };

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev_ps;
    logic [31:0] prev_redir;
    logic [1:0] prev_cls;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("reset taken", 32'(taken_o), 32'h0);
    chk("reset ps", 32'(ps_o), 32'h0);
    chk("reset redirect", redirect_o, 32'h0);
    prev_ps = ps_o; prev_redir = redirect_o; prev_cls = exc_class_o;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_valid = 1'b1; pend_level = TBL[i].pend; cur_level = TBL[i].cur;
      ps_i = TBL[i].ps; int_set = TBL[i].set; int_en = TBL[i].en; pc_i = TBL[i].pc;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R1 take decision", 32'(taken_o), 32'(TBL[i].take));
      if (TBL[i].take) begin
        chk("R2/R6 status word", 32'(ps_o), 32'(TBL[i].ps_x));
        chk("R4/R5 class", 32'(exc_class_o), 32'(TBL[i].cls));
        chk("R7 redirect", redirect_o, TBL[i].redir);
        prev_ps = ps_o; prev_redir = redirect_o; prev_cls = exc_class_o;
      end else begin
        chk("R9 ps held", 32'(ps_o), 32'(prev_ps));
        chk("R9 redirect held", redirect_o, prev_redir);
        chk("R9 class held", 32'(exc_class_o), 32'(prev_cls));
      end
      @(negedge clk);
      chk("R8 strobe single cycle", 32'(taken_o), 32'h0);
      if (i == 3) chk("R9 cause untouched by high level", 32'(cause_o), 32'h0);
      if (i == 4) chk("R3 level-1 cause", 32'(cause_o), 32'd4);
    end

    chk("R2 level-3 saved pc", epc_o[2*PW +: PW], 32'h1000);
    chk("R2 level-3 saved status", 32'(eps_o[1*SW +: SW]), 32'h21);
    chk("R2 level-6 saved pc", epc_o[5*PW +: PW], 32'h5000);
    chk("R2 level-6 saved status", 32'(eps_o[4*SW +: SW]), 32'h05);
    chk("R4 double pc in depc", depc_o, 32'h4000);
    chk("R4 level-1 slot kept on double", epc_o[0 +: PW], 32'h3000);
    chk("R4 no depc fallback slot", epc_b[0 +: PW], 32'h4000);
    chk("R4 no depc register idle", depc_b, 32'h0);
    chk("R3 cause after sequence", 32'(cause_o), 32'd4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule